// File: doc/BRIEF.md
# Atomic Cycle Contention Resolver

This block breaks a mutual wait between the local processor and a remote bus master. The local side may have an indivisible cycle queued and be waiting to own the system bus. At the same moment, a remote master may start an indivisible access into the local shared memory through the bridge. Neither side can then make progress. The block detects this overlap, requests the local bus, and terminates the processor's pending cycle so that the remote access can finish first.

The pending processor cycle is classified from its type code and the atomic-mode setting. Cycle types the processor can reissue are ended with a retry pulse. Read-modify-write cycles cannot be reissued, so they are ended with a bus error pulse. After one termination, the block stays quiet until the processor drops its strobe. It holds the local bus request until the remote access reports completion.

Top module: `atomic_contention_resolver`

## Requirements
- R1: While `rst_ni` is low, `retry_o`, `berr_o` and `local_bus_req_o` are all low.
- R2: With type encoding 2'b00 write, 2'b01 read, 2'b10 read-modify-write, 2'b11 interrupt acknowledge, a pending cycle is atomic if it is a read, a read-modify-write or an interrupt acknowledge, and a write is atomic only while `atomic_mode_i` is high.
- R3: Contention is recognised at a clock edge where `cpu_cyc_valid_i`, `bus_wait_i` and `ext_atomic_start_i` are all high, the pending cycle is atomic, and no earlier termination is still awaiting strobe release. The response is visible on the outputs after that edge.
- R4: On contention with a pending cycle other than read-modify-write, `retry_o` is high for the following cycle and `berr_o` stays low.
- R5: On contention with a pending read-modify-write, `berr_o` is high for the following cycle and `retry_o` stays low.
- R6: `retry_o` and `berr_o` each stay high for exactly one cycle per contention and are never high together.
- R7: After a termination, further contention is ignored and produces no `retry_o` or `berr_o` until `cpu_strobe_i` has been sampled low.
- R8: `local_bus_req_o` rises together with the termination pulse. It stays high until `ext_atomic_done_i` is sampled high, and falls after that edge.
- R9: A pending write with `atomic_mode_i` low never causes `retry_o`, `berr_o` or `local_bus_req_o`.
- R10: `ext_atomic_start_i` has no effect unless both `bus_wait_i` and `cpu_cyc_valid_i` are high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cpu_cyc_valid_i | input | 1 | Processor has a cycle pending for the system bus |
| cpu_cyc_type_i | input | 2 | Type code of the pending cycle |
| atomic_mode_i | input | 1 | Atomic mode on: writes count as atomic |
| bus_wait_i | input | 1 | Bridge is waiting for system bus ownership |
| ext_atomic_start_i | input | 1 | Remote master begins an atomic access to local memory |
| ext_atomic_done_i | input | 1 | Remote atomic access to local memory has completed |
| cpu_strobe_i | input | 1 | Processor address strobe active |
| local_bus_req_o | output | 1 | Request for the local processor bus |
| retry_o | output | 1 | Retry termination to the processor |
| berr_o | output | 1 | Bus error termination to the processor |

## Verification
The bench runs each of the four cycle types into contention, and it runs writes both with atomic mode on and with it off. A wrong classifier would either miss a read or interrupt acknowledge and leave the deadlock in place, or wrongly abort posted writes. It checks that read-modify-write gets a bus error and not a retry; a design that mixed these up would make the processor reissue a cycle that cannot be reissued. It repeats contention while the strobe is still held, and it holds the remote access open across many cycles. These cases catch a design that terminates the same cycle twice or drops the local bus request before the remote access is done. Contention with either the wait or the valid qualifier missing must produce nothing.

// File: rtl/acr_pkg.sv
package acr_pkg;
  localparam int unsigned CYC_TYPE_W = 2;

  typedef enum logic [CYC_TYPE_W-1:0] {
    CYC_WRITE = 2'b00,
    CYC_READ  = 2'b01,
    CYC_RMW   = 2'b10,
    CYC_IACK  = 2'b11
  } cyc_type_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_TERM = 2'b01,
    ST_HOLD = 2'b10
  } term_state_e;
endpackage

// File: rtl/acr_classifier.sv
module acr_classifier
  import acr_pkg::*;
(
  input  logic [CYC_TYPE_W-1:0] cyc_type_i,
  input  logic                  atomic_mode_i,
  output logic                  is_atomic_o,
  output logic                  is_rmw_o
);
  cyc_type_e cyc_type;
  assign cyc_type = cyc_type_e'(cyc_type_i);

  always_comb begin
    case (cyc_type)
      CYC_WRITE: is_atomic_o = atomic_mode_i;
      default:   is_atomic_o = 1'b1;
    endcase
  end

  assign is_rmw_o = (cyc_type == CYC_RMW);
endmodule

// File: rtl/acr_term_fsm.sv
module acr_term_fsm
  import acr_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic is_rmw_i,
  input  logic cpu_strobe_i,
  output logic start_o,
  output logic retry_o,
  output logic berr_o
);
  term_state_e state_q, state_d;
  logic retry_q, berr_q;

  // only one termination per processor cycle
  assign start_o = hit_i && (state_q == ST_IDLE);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (start_o) state_d = ST_TERM;
      ST_TERM: state_d = ST_HOLD;
      ST_HOLD: if (!cpu_strobe_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      retry_q <= 1'b0;
      berr_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      retry_q <= start_o && !is_rmw_i;
      berr_q  <= start_o && is_rmw_i;
    end
  end

  assign retry_o = retry_q;
  assign berr_o  = berr_q;
endmodule

// File: rtl/acr_bus_req.sv
module acr_bus_req (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic req_o
);
  logic req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     req_q <= 1'b0;
    else if (set_i)  req_q <= 1'b1;
    else if (clr_i)  req_q <= 1'b0;
  end

  assign req_o = req_q;
endmodule

// File: rtl/atomic_contention_resolver.sv
module atomic_contention_resolver
  import acr_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cpu_cyc_valid_i,
  input  logic [CYC_TYPE_W-1:0] cpu_cyc_type_i,
  input  logic                  atomic_mode_i,
  input  logic                  bus_wait_i,
  input  logic                  ext_atomic_start_i,
  input  logic                  ext_atomic_done_i,
  input  logic                  cpu_strobe_i,
  output logic                  local_bus_req_o,
  output logic                  retry_o,
  output logic                  berr_o
);
  logic is_atomic, is_rmw, hit, start;

  acr_classifier u_class (
    .cyc_type_i    (cpu_cyc_type_i),
    .atomic_mode_i (atomic_mode_i),
    .is_atomic_o   (is_atomic),
    .is_rmw_o      (is_rmw)
  );

  assign hit = cpu_cyc_valid_i && bus_wait_i && ext_atomic_start_i && is_atomic;

  acr_term_fsm u_term (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .hit_i        (hit),
    .is_rmw_i     (is_rmw),
    .cpu_strobe_i (cpu_strobe_i),
    .start_o      (start),
    .retry_o      (retry_o),
    .berr_o       (berr_o)
  );

  acr_bus_req u_req (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (start),
    .clr_i  (ext_atomic_done_i),
    .req_o  (local_bus_req_o)
  );
endmodule

// File: rtl/acr_checker.sv
module acr_checker
  import acr_pkg::*;
(
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  cpu_cyc_valid_i,
  input logic [CYC_TYPE_W-1:0] cpu_cyc_type_i,
  input logic                  atomic_mode_i,
  input logic                  bus_wait_i,
  input logic                  ext_atomic_start_i,
  input logic                  ext_atomic_done_i,
  input logic                  cpu_strobe_i,
  input logic                  local_bus_req_o,
  input logic                  retry_o,
  input logic                  berr_o
);
  assert_reset_quiet_R1: assert property (@(posedge clk_i)
    !rst_ni |=> (!retry_o && !berr_o) || !rst_ni);

  assert_term_needs_qualifiers_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retry_o || berr_o) |-> ($past(ext_atomic_start_i) && $past(bus_wait_i) && $past(cpu_cyc_valid_i)));

  assert_retry_not_rmw_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retry_o |-> ($past(cpu_cyc_type_i) != CYC_RMW));

  assert_berr_only_rmw_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    berr_o |-> ($past(cpu_cyc_type_i) == CYC_RMW));

  assert_never_both_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({retry_o, berr_o}));

  assert_retry_one_cycle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retry_o |=> !retry_o);

  assert_berr_one_cycle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    berr_o |=> !berr_o);

  assert_req_with_term_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retry_o || berr_o) |-> local_bus_req_o);

  assert_req_held_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (local_bus_req_o && !ext_atomic_done_i) |=> local_bus_req_o);

  assert_posted_write_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retry_o || berr_o) |-> !(($past(cpu_cyc_type_i) == CYC_WRITE) && !$past(atomic_mode_i)));
endmodule

bind atomic_contention_resolver acr_checker u_chk (
  .clk_i              (clk_i),
  .rst_ni             (rst_ni),
  .cpu_cyc_valid_i    (cpu_cyc_valid_i),
  .cpu_cyc_type_i     (cpu_cyc_type_i),
  .atomic_mode_i      (atomic_mode_i),
  .bus_wait_i         (bus_wait_i),
  .ext_atomic_start_i (ext_atomic_start_i),
  .ext_atomic_done_i  (ext_atomic_done_i),
  .cpu_strobe_i       (cpu_strobe_i),
  .local_bus_req_o    (local_bus_req_o),
  .retry_o            (retry_o),
  .berr_o             (berr_o)
);

// File: tb/atomic_contention_resolver_tb.sv
module atomic_contention_resolver_tb;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic valid = 1'b0, amode = 1'b0, bwait = 1'b0, xstart = 1'b0, xdone = 1'b0, strb = 1'b0;
  logic [1:0] ctype = 2'b00;
  logic lbr, retry, berr;

  int checks = 0, errors = 0;
  bit finished = 0;

  typedef struct {
    logic  retry;
    logic  berr;
    logic  lbr;
    string tag;
  } exp_t;
  exp_t sb_q[$];

  // reference model state: 0 idle, 1 terminating, 2 awaiting strobe release
  int   m_state = 0;
  logic m_lbr   = 1'b0;

  always #2 clk = ~clk;

  atomic_contention_resolver u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cpu_cyc_valid_i(valid), .cpu_cyc_type_i(ctype),
    .atomic_mode_i(amode), .bus_wait_i(bwait), .ext_atomic_start_i(xstart),
    .ext_atomic_done_i(xdone), .cpu_strobe_i(strb),
    .local_bus_req_o(lbr), .retry_o(retry), .berr_o(berr)
  );

  task automatic step(input logic v, input logic w, input logic s, input logic d,
                      input logic st, input logic [1:0] t, input logic am, input string tag);
    exp_t e;
    logic atomic, cont;
    @(negedge clk);
    valid = v; bwait = w; xstart = s; xdone = d; strb = st; ctype = t; amode = am;
    atomic = (t == 2'b00) ? am : 1'b1;
    cont = v && w && s && atomic && (m_state == 0);
    e.retry = cont && (t != 2'b10);
    e.berr  = cont && (t == 2'b10);
    e.lbr   = cont ? 1'b1 : (d ? 1'b0 : m_lbr);
    e.tag   = tag;
    sb_q.push_back(e);
    m_lbr = e.lbr;
    case (m_state)
      0: if (cont) m_state = 1;
      1: m_state = 2;
      default: if (!st) m_state = 0;
    endcase
  endtask

  // monitor
  always @(posedge clk) begin
    #1;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      if (retry !== e.retry || berr !== e.berr || lbr !== e.lbr) begin
        errors++;
        $display("FAIL %s: retry/berr/lbr actual %b%b%b expected %b%b%b",
                 e.tag, retry, berr, lbr, e.retry, e.berr, e.lbr);
      end
      checks++;
      if (retry && berr) begin
        errors++;
        $display("FAIL R6: retry and berr both high, actual 11 expected not 11");
      end
    end
  end

  task automatic contend(input logic [1:0] t, input logic am, input string tag);
    step(1, 1, 1, 0, 1, t, am, tag);
    step(1, 1, 0, 0, 1, t, am, "R6");
    step(1, 1, 1, 0, 1, t, am, "R7");
    step(1, 1, 1, 0, 1, t, am, "R7");
    step(0, 0, 0, 0, 0, t, am, "R7");
    step(0, 0, 0, 1, 0, t, am, "R8");
    step(0, 0, 0, 0, 0, t, am, "R8");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (retry !== 1'b0 || berr !== 1'b0 || lbr !== 1'b0) begin
      errors++;
      $display("FAIL R1: retry/berr/lbr actual %b%b%b expected 000", retry, berr, lbr);
    end
    rst_ni = 1'b1;
    step(0, 0, 0, 0, 0, 2'b00, 0, "R1");
    contend(2'b01, 0, "R4");
    contend(2'b10, 0, "R5");
    contend(2'b11, 0, "R2");
    contend(2'b00, 1, "R2");
    contend(2'b00, 0, "R9");
    contend(2'b10, 1, "R3");
    step(0, 1, 1, 0, 1, 2'b01, 0, "R10");
    step(1, 0, 1, 0, 1, 2'b01, 0, "R10");
    step(1, 1, 0, 0, 1, 2'b10, 0, "R3");
    step(0, 0, 0, 0, 0, 2'b00, 0, "R10");
    // long remote access: request must persist
    step(1, 1, 1, 0, 1, 2'b11, 0, "R4");
    for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 0, 2'b00, 0, "R8");
    step(0, 0, 0, 1, 0, 2'b00, 0, "R8");
    step(0, 0, 0, 0, 0, 2'b00, 0, "R8");
    // contention cycle exactly when strobe is released
    step(1, 1, 1, 0, 1, 2'b01, 0, "R4");
    step(1, 1, 0, 0, 1, 2'b01, 0, "R6");
    step(1, 1, 1, 0, 0, 2'b01, 0, "R7");
    step(1, 1, 1, 1, 1, 2'b01, 0, "R3");
    step(0, 0, 0, 1, 0, 2'b01, 0, "R8");
    step(0, 0, 0, 0, 0, 2'b00, 0, "R8");
    repeat (3) @(posedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule